// File: doc/BRIEF.md
# Serial CRC Engine with Length-Dependent Word Queue

This block computes a cyclic redundancy check over a stream of data words. Software sets three things: a word length from 1 to 16 bits, a polynomial mask and, optionally, a starting seed. It then loads words one byte at a time into a small internal queue. Once a go bit is set, the engine takes one bit per clock from the oldest queued word, most significant data bit first, and feeds it into a Galois-style linear feedback register. That register is as wide as the word.

The queue holds 16 words when the word length is 8 bits or less, and 8 words when it is longer. A valid-word counter tracks the queue. It grows when the byte holding a word's top data bit is written, and it shrinks when the last bit of a word has been shifted. Full and empty flags are taken from this counter. A single-cycle interrupt pulse marks the counter draining from one to zero by shifting. A write into a full queue does not overflow: it resets the queue to empty and raises no interrupt. A suspend input freezes the whole block.

Top module: `crc_fifo_engine`

## Requirements
- R1: After reset, crc_out is 0, word_count is 0, empty is 1, full is 0, go is 0 and irq is 0.
- R2: A word uses its low len+1 bits, where len is the 4-bit length field. Lane 0 carries bits 7:0 and lane 1 carries bits 15:8, and data bits above len are ignored. When len ≤ 7, a lane 0 write completes a word and a lane 1 write is ignored. When len > 7, a lane 0 write only stages the low byte, and a lane 1 write completes the word.
- R3: The queue depth is 16 when len ≤ 7 and 8 when len > 7. The full output is 1 exactly when word_count equals the depth, and the empty output is 1 exactly when word_count is 0.
- R4: Shifting happens only while go is 1 and word_count is nonzero. It moves one bit per clock, starting at bit len and ending at bit 0, so a batch of N words finishes len+1 times N clocks after go is seen.
- R5: The CRC register has len+1 active bits. With fb = crc[len] XOR din, the next value of bit i is crc[i-1] XOR (poly[i] AND fb) for 1 ≤ i ≤ len, bit 0 becomes poly[0] AND fb, and bits above len become 0. With len=15 and poly=16'h1021 this is the x^16+x^12+x^5+1 generator.
- R6: word_count drops by one when bit 0 of a word has been shifted. If a word completes in that same cycle, word_count is unchanged.
- R7: A word completed while full is 1 sets word_count to 0. The queue then behaves as empty, and irq stays 0.
- R8: irq is 1 for exactly one clock when word_count goes from 1 to 0 through shifting. It is not raised when a word completes in the same cycle as that last shift.
- R9: A seed write loads crc_out with the seed masked to len+1 bits, but only while go is 0. While go is 1 the seed write is ignored.
- R10: While suspend is 1, the CRC register, the queue, word_count and all configuration stay unchanged, and every write is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| suspend | input | 1 | Freezes all state and blocks writes |
| len_we | input | 1 | Write strobe for the length field |
| len_wdata | input | 4 | Word length minus one |
| poly_we | input | 1 | Write strobe for the polynomial mask |
| poly_wdata | input | 16 | Polynomial mask, bit i is the x^i coefficient |
| go_we | input | 1 | Write strobe for the go bit |
| go_wdata | input | 1 | New go value |
| seed_we | input | 1 | Write strobe for the CRC seed |
| seed_wdata | input | 16 | Seed value |
| data_we | input | 1 | Byte write strobe into the queue |
| data_lane | input | 1 | Byte lane: 0 for bits 7:0, 1 for bits 15:8 |
| data_wdata | input | 8 | Byte to write |
| crc_out | output | 16 | Current CRC register |
| word_count | output | 5 | Valid-word count |
| full | output | 1 | Queue full flag |
| empty | output | 1 | Queue empty flag |
| go | output | 1 | Current go bit |
| irq | output | 1 | Single-cycle drain interrupt |

## Verification
Two events can land on the same clock edge: a word completing in the queue, and the final bit of the last queued word being shifted out. To provoke this, the bench starts a one-word batch and times a completing byte write to arrive on exactly the edge that shifts bit 0. It then judges three things. The count must stay at one, irq must stay low on that edge, and the pulse must appear only when the second word has drained, with a CRC that matches a model fed both words. A second collision sets a write to a full queue against go being low, and checks for the wrap to empty with no pulse.

// File: rtl/crc_fifo_engine.sv
module crc_fifo_engine #(
  parameter int DEPTH_MAX = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        suspend,
  input  logic        len_we,
  input  logic [3:0]  len_wdata,
  input  logic        poly_we,
  input  logic [15:0] poly_wdata,
  input  logic        go_we,
  input  logic        go_wdata,
  input  logic        seed_we,
  input  logic [15:0] seed_wdata,
  input  logic        data_we,
  input  logic        data_lane,
  input  logic [7:0]  data_wdata,
  output logic [15:0] crc_out,
  output logic [4:0]  word_count,
  output logic        full,
  output logic        empty,
  output logic        go,
  output logic        irq
);
  localparam int DEPTH_MIN = DEPTH_MAX / 2;
  localparam int PW = $clog2(DEPTH_MAX);
  localparam int CW = PW + 1;

  logic [3:0]    len_q;
  logic [15:0]   poly_q, crc_q, crc_nxt;
  logic [15:0]   mem [DEPTH_MAX];
  logic [7:0]    lo_hold;
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count_q;
  logic [3:0]    bit_off;
  logic          go_q, irq_q;

  wire           wide   = len_q[3];
  wire [CW-1:0]  depth  = wide ? CW'(DEPTH_MIN) : CW'(DEPTH_MAX);
  wire [PW-1:0]  pmask  = PW'(depth - 1'b1);
  wire           push   = !suspend && data_we && (data_lane == wide);
  wire [15:0]    word_in = wide ? {data_wdata, lo_hold} : {8'h00, data_wdata};
  wire           is_full = (count_q == depth);
  wire           is_empty = (count_q == '0);
  wire           wrap   = push && is_full;
  wire           shift  = !suspend && go_q && !is_empty;
  wire           pop    = shift && (bit_off == len_q);
  wire [3:0]     bit_sel = len_q - bit_off;
  wire [15:0]    head   = mem[rd_ptr];
  wire           din    = head[bit_sel];
  wire           fb     = crc_q[len_q] ^ din;
  wire [15:0]    lmask  = 16'hFFFF >> (4'd15 - len_q);

  always_comb begin
    for (int i = 0; i < 16; i++) begin
      if (i <= int'(len_q))
        crc_nxt[i] = ((i == 0) ? 1'b0 : crc_q[(i == 0) ? 0 : i-1]) ^ (poly_q[i] & fb);
      else
        crc_nxt[i] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (push && !is_full) mem[wr_ptr] <= word_in;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      len_q   <= '0;
      poly_q  <= '0;
      crc_q   <= '0;
      lo_hold <= '0;
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      count_q <= '0;
      bit_off <= '0;
      go_q    <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      irq_q <= pop && (count_q == CW'(1)) && !push;
      if (!suspend) begin
        if (len_we)  len_q  <= len_wdata;
        if (poly_we) poly_q <= poly_wdata;
        if (go_we)   go_q   <= go_wdata;
        if (seed_we && !go_q) crc_q <= seed_wdata & lmask;
        else if (shift)       crc_q <= crc_nxt;
        if (data_we && !data_lane && wide) lo_hold <= data_wdata;
        if (wrap) begin
          wr_ptr  <= '0;
          rd_ptr  <= '0;
          count_q <= '0;
          bit_off <= '0;
        end else begin
          if (push) wr_ptr <= (wr_ptr + 1'b1) & pmask;
          if (pop) begin
            rd_ptr  <= (rd_ptr + 1'b1) & pmask;
            bit_off <= '0;
          end else if (shift) begin
            bit_off <= bit_off + 1'b1;
          end
          count_q <= count_q + CW'(push) - CW'(pop);
        end
      end
    end
  end

  assign crc_out    = crc_q;
  assign word_count = count_q;
  assign full       = is_full;
  assign empty      = is_empty;
  assign go         = go_q;
  assign irq        = irq_q;

  a_r3_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    count_q <= CW'(DEPTH_MAX));
  a_r7_wrap_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (data_we && !suspend && (data_lane == len_q[3]) && full) |=> (word_count == '0 && !irq));
  a_r8_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (word_count == '0 && $past(word_count) == 5'd1));
  a_r8_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);
  a_r10_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    suspend |=> ($stable(crc_out) && $stable(word_count) && $stable(rd_ptr) && $stable(len_q)));
  a_r4_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!go && !seed_we) |=> $stable(crc_out));
endmodule

// File: tb/crc_fifo_engine_bench.sv
module crc_fifo_engine_bench;
  logic clk = 0, rst_n = 0, suspend = 0;
  logic len_we = 0, poly_we = 0, go_we = 0, go_wdata = 0, seed_we = 0, data_we = 0, data_lane = 0;
  logic [3:0] len_wdata = 0;
  logic [15:0] poly_wdata = 0, seed_wdata = 0;
  logic [7:0] data_wdata = 0;
  logic [15:0] crc_out;
  logic [4:0] word_count;
  logic full, empty, go, irq;

  int checks = 0, errors = 0, irq_seen = 0;
  bit done = 0;
  logic [3:0] m_len;
  logic [15:0] m_poly, m_crc;

  always #2 clk = ~clk;

  crc_fifo_engine u_crc_fifo_engine (.*);

  always @(negedge clk) if (irq) irq_seen++;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] step(input logic [15:0] c, input logic d);
    logic fbit = c[m_len] ^ d;
    logic [15:0] r = '0;
    for (int i = 0; i <= 15; i++)
      if (i <= int'(m_len)) r[i] = ((i > 0) ? c[(i > 0) ? i-1 : 0] : 1'b0) ^ (m_poly[i] & fbit);
    return r;
  endfunction

  function automatic void model_word(input logic [15:0] w);
    for (int b = 15; b >= 0; b--)
      if (b <= int'(m_len)) m_crc = step(m_crc, w[b]);
  endfunction

  task automatic pulse_cfg(input logic [3:0] l, input logic [15:0] p);
    @(negedge clk); len_we = 1; len_wdata = l; poly_we = 1; poly_wdata = p;
    @(negedge clk); len_we = 0; poly_we = 0;
    m_len = l; m_poly = p;
  endtask

  task automatic wr_seed(input logic [15:0] s);
    @(negedge clk); seed_we = 1; seed_wdata = s;
    @(negedge clk); seed_we = 0;
  endtask

  task automatic wr_byte(input logic lane, input logic [7:0] b);
    @(negedge clk); data_we = 1; data_lane = lane; data_wdata = b;
    @(negedge clk); data_we = 0;
  endtask

  task automatic push_word(input logic [15:0] w);
    if (m_len > 7) begin wr_byte(0, w[7:0]); wr_byte(1, w[15:8]); end
    else wr_byte(0, w[7:0]);
  endtask

  task automatic set_go(input logic v);
    @(negedge clk); go_we = 1; go_wdata = v;
    @(negedge clk); go_we = 0;
  endtask

  task automatic run_batch(input string req, input int nwords, input int extra);
    int cyc = 0;
    @(negedge clk); go_we = 1; go_wdata = 1;
    do begin @(negedge clk); go_we = 0; cyc++; end while (word_count != 0 && cyc < 2000);
    chk({req, " batch cycles"}, cyc, (int'(m_len) + 1) * nwords + 1 + extra);
    chk("R8 irq at drain", irq, 1);
    chk("R5 crc", crc_out, m_crc);
    @(negedge clk);
    chk("R8 irq one cycle", irq, 0);
    set_go(0);
  endtask

  task automatic t_reset;
    chk("R1 crc", crc_out, 0);
    chk("R1 count", word_count, 0);
    chk("R1 empty", empty, 1);
    chk("R1 full", full, 0);
    chk("R1 go", go, 0);
    chk("R1 irq", irq, 0);
  endtask

  task automatic t_ccitt;
    logic [15:0] ws [3] = '{16'h3132, 16'hA55A, 16'h0F0F};
    pulse_cfg(4'd15, 16'h1021);
    wr_seed(16'h0000); m_crc = 0;
    foreach (ws[i]) begin push_word(ws[i]); model_word(ws[i]); end
    chk("R2 R6 count after three words", word_count, 3);
    run_batch("R4 R6", 3, 0);
  endtask

  task automatic t_short;
    pulse_cfg(4'd4, 16'h0005);
    wr_seed(16'hFFDA); m_crc = 16'h001A;
    chk("R9 seed masked", crc_out, 16'h001A);
    wr_byte(1, 8'h77);
    chk("R2 high lane ignored at short len", word_count, 0);
    wr_byte(0, 8'hE9); model_word(16'h0009);
    wr_byte(0, 8'h36); model_word(16'h0016);
    chk("R2 count short words", word_count, 2);
    run_batch("R4 R2", 2, 0);
  endtask

  task automatic t_depth;
    int s;
    pulse_cfg(4'd7, 16'h0007);
    for (int i = 0; i < 16; i++) wr_byte(0, 8'(i));
    chk("R3 count at depth 16", word_count, 16);
    chk("R3 full at 16", full, 1);
    s = irq_seen;
    wr_byte(0, 8'hAA);
    chk("R7 wrap count", word_count, 0);
    chk("R7 wrap empty", empty, 1);
    chk("R7 no irq on wrap", irq_seen, s);
    pulse_cfg(4'd15, 16'h8005);
    wr_byte(0, 8'h11);
    chk("R2 low lane only stages", word_count, 0);
    wr_byte(1, 8'h22);
    for (int i = 1; i < 7; i++) push_word(16'(i * 16'h0101));
    chk("R3 not full at 7", full, 0);
    push_word(16'hBEEF);
    chk("R3 full at depth 8", full, 1);
    chk("R3 count at depth 8", word_count, 8);
    push_word(16'h1234);
    chk("R7 wrap at depth 8", word_count, 0);
    chk("R7 no irq wide wrap", irq_seen, s);
    chk("R3 empty after wrap", empty, 1);
  endtask

  task automatic t_idle_seed;
    logic [15:0] c;
    pulse_cfg(4'd15, 16'h1021);
    wr_seed(16'h4321); m_crc = 16'h4321;
    push_word(16'h00FF);
    c = crc_out;
    repeat (20) @(negedge clk);
    chk("R4 no shift while go low crc", crc_out, c);
    chk("R4 no shift while go low count", word_count, 1);
    set_go(1);
    @(negedge clk);
    set_go(0);
    push_word(16'h0000);
    set_go(1);
    wr_seed(16'h9999);
    repeat (40) @(negedge clk);
    set_go(0);
    model_word(16'h00FF); model_word(16'h0000);
    chk("R9 seed ignored while go", crc_out, m_crc);
    chk("R6 drained", word_count, 0);
  endtask

  task automatic t_suspend;
    int cyc = 0;
    logic [15:0] c;
    logic [4:0] n;
    pulse_cfg(4'd11, 16'h080F);
    wr_seed(16'h0ABC); m_crc = 16'h0ABC;
    push_word(16'h0123); model_word(16'h0123);
    push_word(16'h0FED); model_word(16'h0FED);
    @(negedge clk); go_we = 1; go_wdata = 1;
    repeat (5) begin @(negedge clk); go_we = 0; cyc++; end
    suspend = 1;
    @(negedge clk); cyc++;
    c = crc_out; n = word_count;
    data_we = 1; data_lane = 1; data_wdata = 8'h55; len_we = 1; len_wdata = 4'd2;
    @(negedge clk); cyc++;
    data_we = 0; len_we = 0;
    repeat (8) begin @(negedge clk); cyc++; end
    chk("R10 crc frozen", crc_out, c);
    chk("R10 count frozen and write ignored", word_count, n);
    suspend = 0;
    do begin @(negedge clk); cyc++; end while (word_count != 0 && cyc < 2000);
    chk("R10 batch cycles with hold", cyc, 12 * 2 + 1 + 10);
    chk("R10 crc after resume", crc_out, m_crc);
    set_go(0);
  endtask

  task automatic t_collide;
    int s;
    pulse_cfg(4'd3, 16'h0003);
    wr_seed(16'h0005); m_crc = 16'h0005;
    wr_byte(0, 8'h0B); model_word(16'h000B);
    s = irq_seen;
    @(negedge clk); go_we = 1; go_wdata = 1;
    @(negedge clk); go_we = 0;
    repeat (2) @(negedge clk);
    @(negedge clk); data_we = 1; data_lane = 0; data_wdata = 8'hF6;
    @(negedge clk); data_we = 0;
    chk("R6 count kept on push with last pop", word_count, 1);
    chk("R8 no irq on collision", irq_seen, s);
    model_word(16'h0006);
    while (word_count != 0) @(negedge clk);
    chk("R8 irq after second word", irq, 1);
    chk("R5 crc both words", crc_out, m_crc);
    set_go(0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R4 watchdog actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_ccitt();
    t_short();
    t_depth();
    t_idle_seed();
    t_suspend();
    t_collide();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule